// File: doc/BRIEF.md
# Program Trace Window Capture Unit

This block sits beside a processor and watches two status buses that change on every clock: a 3-bit flow code and a 2-bit flush code. It also watches the bus addresses of cycles that the processor tags as indirect change-of-flow. Once capture has begun, it stores one status sample on every clock. A tagged address is stored in any clock where one appears. Both kinds of entry go into one small on-chip FIFO, and each entry carries a type bit. The trace consumer drains that FIFO through a simple read port.

Capture can begin in one of two ways, picked by a static mode input. In back-trace mode it begins on the first clock after reset is released. In window-trace mode it waits for a synchronization marker. That marker uses the same flow code (011) that otherwise reports flush information, so the block decodes it from the code seen on the previous clock.

The block also works out where the trace window starts. The answer depends on the kind of instruction reported right after the marker. It can be the first tagged address, the second tagged address, or a direct-branch target. A direct-branch target needs the branch displacement, which the block fetches through a request/response lookup port.

Top module: `trace_window_capture`

## Requirements
- R1: A flow code of 011 is taken as the sync marker only when the flow code on the previous clock was 000, 001 or 010. On the first clock after reset there is no previous code, so 011 there is never a marker.
- R2: In window mode nothing is stored before the marker. The marker clock's status sample is the first entry, and `capturing` goes high after that clock and stays high until reset.
- R3: In back mode, capture begins on the first clock after reset is released, and that clock's status sample is the first entry.
- R4: While capturing, every clock stores one status entry. Bit ADDR_W of the entry is 0, bits [4:3] hold the flush code, bits [2:0] hold the flow code, and every other bit is 0.
- R5: A tagged address seen while capturing is stored as an entry with bit ADDR_W set to 1 and the address in the low ADDR_W bits. When a status sample and an address fall in the same clock, the status entry is stored first.
- R6: In window mode, if the flow code on the clock after the marker is 001, the start address is the first tagged address stored (T1).
- R7: If that code is 110, the block raises `lk_req_valid` with `lk_req_addr` = T1 − 4 and holds both until `lk_rsp_ready`. The start address is then T1 − 4 plus the sign-extended `lk_rsp_offset`, and `start_valid` is never high while the request is pending.
- R8: If that code is 101, the start address is the second tagged address stored (T2).
- R9: For any other code after the marker, `start_err` rises instead, `start_valid` stays low, and capture and storage carry on.
- R10: In back mode the start address is the first tagged address stored.
- R11: An entry that finds the FIFO full (occupancy counted before this clock's read) is dropped. `overflow` then goes high and stays high until reset.
- R12: `rd_valid` is high while the FIFO holds entries. `rd_data` shows the oldest entry, `rd_en` removes it, and entries leave in the order they were stored.
- R13: Once `start_valid` or `start_err` is high, it and `start_addr` hold until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_window | input | 1 | 1 = window-trace mode, 0 = back-trace mode (static) |
| flow_code | input | 3 | Per-clock flow status code |
| flush_code | input | 2 | Per-clock flush status code |
| tag_valid | input | 1 | A tagged indirect change-of-flow address is on `tag_addr` |
| tag_addr | input | ADDR_W | Tagged bus address |
| lk_req_valid | output | 1 | Branch-offset lookup request pending |
| lk_req_addr | output | ADDR_W | Address of the direct branch to look up |
| lk_rsp_ready | input | 1 | Lookup response present; completes the request |
| lk_rsp_offset | input | OFF_W | Signed branch displacement |
| start_valid | output | 1 | `start_addr` is resolved |
| start_err | output | 1 | The code after the marker cannot place the window start |
| start_addr | output | ADDR_W | Trace window start address |
| capturing | output | 1 | Capture has begun |
| rd_en | input | 1 | Remove the oldest FIFO entry |
| rd_valid | output | 1 | FIFO is not empty |
| rd_data | output | ADDR_W+1 | Oldest entry: type bit at the top, payload below |
| overflow | output | 1 | Sticky: an entry was dropped |

## Verification
The status sample and the tagged address can both need a FIFO slot in the same clock, and a FIFO read can happen in that clock as well. The bench raises a tag on every clock, so each clock makes two pushes. It walks occupancy up to exactly one free slot, where the status entry must be kept and the address dropped. It also drains the FIFO while capture keeps pushing. The drained order, the dropped entry and the point where `overflow` rises are all judged against a bench-side occupancy count taken before each clock's read.

// File: rtl/twc_pkg.sv
`timescale 1ns/1ps
// twc_pkg: shared codes and state types for the trace window capture unit.
// Assumes a 3-bit flow code and a 2-bit flush code on the status buses.
package twc_pkg;
    localparam logic [2:0] FC_MARK = 3'b011;
    localparam logic [2:0] FC_SEQ  = 3'b001;
    localparam logic [2:0] FC_DIR  = 3'b110;
    localparam logic [2:0] FC_IND  = 3'b101;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_NEXT,
        PH_RESOLVE,
        PH_LOOKUP,
        PH_DONE,
        PH_ERROR
    } phase_t;

    typedef enum logic [1:0] {
        K_SEQ,
        K_DIR,
        K_IND
    } kind_t;
endpackage

// File: rtl/twc_sync_detect.sv
`timescale 1ns/1ps
// twc_sync_detect: flags the sync marker in the shared flow code.
// Code 011 is a marker only when the previous clock's code was 000, 001
// or 010. The first clock after reset has no previous code.
module twc_sync_detect
    import twc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] flow_code,
    output logic       sync_now
);
    logic [2:0] prev_code;
    logic       prev_ok;
    logic       prev_allows;

    // Remember the code from the previous clock and whether it exists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_code <= 3'b111;
            prev_ok   <= 1'b0;
        end else begin
            prev_code <= flow_code;
            prev_ok   <= 1'b1;
        end
    end

    // Previous codes that allow the next 011 to be read as a marker.
    always_comb begin
        case (prev_code)
            3'b000, 3'b001, 3'b010: prev_allows = 1'b1;
            default:                prev_allows = 1'b0;
        endcase
    end

    // Marker decision for the current clock.
    always_comb sync_now = prev_ok && prev_allows && (flow_code == FC_MARK);
endmodule

// File: rtl/twc_capture_ctrl.sv
`timescale 1ns/1ps
// twc_capture_ctrl: decides on which clocks samples are stored.
// Back mode stores from the first clock out of reset. Window mode stores
// from the marker clock on. mode_window is assumed static between resets.
module twc_capture_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_window,
    input  logic sync_now,
    output logic active,
    output logic capturing
);
    logic cap_on;

    // Latch that capture has begun.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_on <= 1'b0;
        else        cap_on <= active;
    end

    // Storage is enabled on the starting clock and on every clock after it.
    always_comb active = cap_on | (mode_window ? sync_now : 1'b1);

    // Export the latched state.
    always_comb capturing = cap_on;
endmodule

// File: rtl/twc_fifo.sv
`timescale 1ns/1ps
// twc_fifo: capture buffer with two write ports per clock and one read.
// Port A (status) goes ahead of port B (address). Writes that do not fit
// are dropped, and a sticky overflow flag is raised. Free space is counted
// before this clock's read. DEPTH must be a power of two and at least 2.
// Storage is not reset.
module twc_fifo #(
    parameter int WIDTH = 33,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_a,
    input  logic [WIDTH-1:0] data_a,
    input  logic             push_b,
    input  logic [WIDTH-1:0] data_b,
    input  logic             pop,
    output logic             not_empty,
    output logic [WIDTH-1:0] head,
    output logic             overflow
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wp, rp, wp_b;
    logic [CNT_W-1:0] count, free;
    logic             acc_a, acc_b, pop_ok;
    logic [1:0]       n_acc;

    // Admission: A needs one slot, B needs one more if A was taken.
    always_comb begin
        free   = CNT_W'(DEPTH) - count;
        acc_a  = push_a && (free != '0);
        acc_b  = push_b && (free >= (push_a ? CNT_W'(2) : CNT_W'(1)));
        n_acc  = {1'b0, acc_a} + {1'b0, acc_b};
        pop_ok = pop && (count != '0);
        wp_b   = wp + PTR_W'(acc_a);
    end

    // One storage slot per entry; A has the slot at wp, B the one after.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (acc_a && (wp == PTR_W'(i)))        mem[i] <= data_a;
            else if (acc_b && (wp_b == PTR_W'(i))) mem[i] <= data_b;
        end
    end

    // Pointers, occupancy and the sticky drop flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp       <= '0;
            rp       <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            wp       <= wp + PTR_W'(n_acc);
            rp       <= rp + PTR_W'(pop_ok);
            count    <= count + CNT_W'(n_acc) - CNT_W'(pop_ok);
            overflow <= overflow | (push_a && !acc_a) | (push_b && !acc_b);
        end
    end

    // Read side shows the oldest entry.
    always_comb begin
        not_empty = (count != '0);
        head      = mem[rp];
    end
endmodule

// File: rtl/twc_start_resolver.sv
`timescale 1ns/1ps
// twc_start_resolver: works out the trace window start address.
// It records the first two tagged addresses stored (T1, T2) and, in window
// mode, the flow code on the clock after the marker. A direct-branch start
// asks the lookup port for the displacement of the branch at T1 - INSN_BYTES.
// It assumes OFF_W < ADDR_W and that a response completes on the clock
// where lk_rsp_ready is high.
module twc_start_resolver
    import twc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 16,
    parameter int INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_window,
    input  logic              active,
    input  logic [2:0]        flow_code,
    input  logic              tag_push,
    input  logic [ADDR_W-1:0] tag_addr,
    input  logic              lk_rsp_ready,
    input  logic [OFF_W-1:0]  lk_rsp_offset,
    output logic              lk_req_valid,
    output logic [ADDR_W-1:0] lk_req_addr,
    output logic              start_valid,
    output logic              start_err,
    output logic [ADDR_W-1:0] start_addr
);
    localparam int EXT_W = ADDR_W - OFF_W;

    phase_t            phase;
    kind_t             kind;
    logic [ADDR_W-1:0] t1, t2, branch_pc, off_ext;
    logic [1:0]        ntag;

    // Address of the direct branch and its sign-extended displacement.
    always_comb begin
        branch_pc = t1 - ADDR_W'(INSN_BYTES);
        off_ext   = {{EXT_W{lk_rsp_offset[OFF_W-1]}}, lk_rsp_offset};
    end

    // Record the first two tagged addresses in storage order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t1   <= '0;
            t2   <= '0;
            ntag <= 2'd0;
        end else if (tag_push) begin
            if (ntag == 2'd0)      t1 <= tag_addr;
            else if (ntag == 2'd1) t2 <= tag_addr;
            if (ntag != 2'd2) ntag <= ntag + 2'd1;
        end
    end

    // Resolution sequence: wait for the start, classify, gather, look up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            kind       <= K_SEQ;
            start_addr <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (active) begin
                        kind  <= K_SEQ;
                        phase <= mode_window ? PH_NEXT : PH_RESOLVE;
                    end
                end
                PH_NEXT: begin
                    phase <= PH_RESOLVE;
                    case (flow_code)
                        FC_SEQ:  kind <= K_SEQ;
                        FC_DIR:  kind <= K_DIR;
                        FC_IND:  kind <= K_IND;
                        default: phase <= PH_ERROR;
                    endcase
                end
                PH_RESOLVE: begin
                    case (kind)
                        K_SEQ: begin
                            if (ntag != 2'd0) begin
                                start_addr <= t1;
                                phase      <= PH_DONE;
                            end
                        end
                        K_IND: begin
                            if (ntag == 2'd2) begin
                                start_addr <= t2;
                                phase      <= PH_DONE;
                            end
                        end
                        K_DIR: begin
                            if (ntag != 2'd0) phase <= PH_LOOKUP;
                        end
                        default: phase <= PH_ERROR;
                    endcase
                end
                PH_LOOKUP: begin
                    if (lk_rsp_ready) begin
                        start_addr <= branch_pc + off_ext;
                        phase      <= PH_DONE;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs decoded from the phase.
    always_comb begin
        lk_req_valid = (phase == PH_LOOKUP);
        lk_req_addr  = branch_pc;
        start_valid  = (phase == PH_DONE);
        start_err    = (phase == PH_ERROR);
    end
endmodule

// File: rtl/trace_window_capture.sv
`timescale 1ns/1ps
// trace_window_capture: top of the program trace window capture unit.
// It stores per-clock status samples and sporadic tagged addresses in a
// typed FIFO and works out the trace window start address. The entry's
// top bit is 1 for an address and 0 for a status sample.
// mode_window is assumed stable between resets.
module trace_window_capture #(
    parameter int ADDR_W     = 32,
    parameter int OFF_W      = 16,
    parameter int FIFO_DEPTH = 8,
    parameter int INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_window,
    input  logic [2:0]        flow_code,
    input  logic [1:0]        flush_code,
    input  logic              tag_valid,
    input  logic [ADDR_W-1:0] tag_addr,
    output logic              lk_req_valid,
    output logic [ADDR_W-1:0] lk_req_addr,
    input  logic              lk_rsp_ready,
    input  logic [OFF_W-1:0]  lk_rsp_offset,
    output logic              start_valid,
    output logic              start_err,
    output logic [ADDR_W-1:0] start_addr,
    output logic              capturing,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [ADDR_W:0]   rd_data,
    output logic              overflow
);
    localparam int ENTRY_W = ADDR_W + 1;
    localparam int PAD_W   = ADDR_W - 5;

    logic               sync_now, active, tag_push;
    logic [ENTRY_W-1:0] status_entry, addr_entry;

    twc_sync_detect u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .flow_code(flow_code),
        .sync_now (sync_now)
    );

    twc_capture_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_window(mode_window),
        .sync_now   (sync_now),
        .active     (active),
        .capturing  (capturing)
    );

    // Build the two typed entries for this clock.
    always_comb begin
        tag_push     = active && tag_valid;
        status_entry = {1'b0, {PAD_W{1'b0}}, flush_code, flow_code};
        addr_entry   = {1'b1, tag_addr};
    end

    twc_fifo #(
        .WIDTH(ENTRY_W),
        .DEPTH(FIFO_DEPTH)
    ) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_a   (active),
        .data_a   (status_entry),
        .push_b   (tag_push),
        .data_b   (addr_entry),
        .pop      (rd_en),
        .not_empty(rd_valid),
        .head     (rd_data),
        .overflow (overflow)
    );

    twc_start_resolver #(
        .ADDR_W    (ADDR_W),
        .OFF_W     (OFF_W),
        .INSN_BYTES(INSN_BYTES)
    ) u_start (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_window  (mode_window),
        .active       (active),
        .flow_code    (flow_code),
        .tag_push     (tag_push),
        .tag_addr     (tag_addr),
        .lk_rsp_ready (lk_rsp_ready),
        .lk_rsp_offset(lk_rsp_offset),
        .lk_req_valid (lk_req_valid),
        .lk_req_addr  (lk_req_addr),
        .start_valid  (start_valid),
        .start_err    (start_err),
        .start_addr   (start_addr)
    );
endmodule

// File: rtl/twc_checker.sv
`timescale 1ns/1ps
// twc_checker: temporal properties of trace_window_capture, bound to it.
module twc_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_window,
    input logic [2:0]        flow_code,
    input logic              capturing,
    input logic              start_valid,
    input logic              start_err,
    input logic [ADDR_W-1:0] start_addr,
    input logic              lk_req_valid,
    input logic              lk_rsp_ready,
    input logic [ADDR_W-1:0] lk_req_addr,
    input logic              overflow
);
    AST_CAPTURE_FROM_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_window && $rose(capturing)) |-> ($past(flow_code) == 3'b011)); // R2
    AST_CAPTURE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        capturing |=> capturing); // R2
    AST_LOOKUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req_valid && !lk_rsp_ready) |=> (lk_req_valid && $stable(lk_req_addr))); // R7
    AST_NO_START_DURING_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_req_valid && start_valid)); // R7
    AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_valid && start_err)); // R9
    AST_OVERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R11
    AST_START_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |=> (start_valid && $stable(start_addr))); // R13
    AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        start_err |=> start_err); // R13
endmodule

bind trace_window_capture twc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_window (mode_window),
    .flow_code   (flow_code),
    .capturing   (capturing),
    .start_valid (start_valid),
    .start_err   (start_err),
    .start_addr  (start_addr),
    .lk_req_valid(lk_req_valid),
    .lk_rsp_ready(lk_rsp_ready),
    .lk_req_addr (lk_req_addr),
    .overflow    (overflow)
);

// File: tb/sim_trace_window_capture.sv
`timescale 1ns/1ps
// sim_trace_window_capture: sweeps marker context, the code after the
// marker, lookup latency, both modes and the FIFO full boundary.
module sim_trace_window_capture;
    localparam int AW    = 32;
    localparam int OW    = 16;
    localparam int DEPTH = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_window = 1'b0;
    logic [2:0]    flow_code = '0;
    logic [1:0]    flush_code = '0;
    logic          tag_valid = 1'b0;
    logic [AW-1:0] tag_addr = '0;
    logic          lk_req_valid;
    logic [AW-1:0] lk_req_addr;
    logic          lk_rsp_ready = 1'b0;
    logic [OW-1:0] lk_rsp_offset = '0;
    logic          start_valid, start_err, capturing, rd_valid, overflow;
    logic [AW-1:0] start_addr;
    logic          rd_en = 1'b0;
    logic [AW:0]   rd_data;

    always #10 clk = ~clk;

    trace_window_capture #(
        .ADDR_W(AW), .OFF_W(OW), .FIFO_DEPTH(DEPTH), .INSN_BYTES(4)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .mode_window(mode_window),
        .flow_code(flow_code), .flush_code(flush_code),
        .tag_valid(tag_valid), .tag_addr(tag_addr),
        .lk_req_valid(lk_req_valid), .lk_req_addr(lk_req_addr),
        .lk_rsp_ready(lk_rsp_ready), .lk_rsp_offset(lk_rsp_offset),
        .start_valid(start_valid), .start_err(start_err), .start_addr(start_addr),
        .capturing(capturing), .rd_en(rd_en), .rd_valid(rd_valid),
        .rd_data(rd_data), .overflow(overflow)
    );

    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;
    logic [AW:0] exq [$];
    bit          m_mode, m_cap, m_hasprev, m_ovf;
    logic [2:0]  m_prev;
    int          lat_set = 0;
    int          lat_cnt = 0;
    logic [AW-1:0] exp_lk = '0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [OW-1:0] off_of(input logic [AW-1:0] a);
        return OW'(a[11:0]) - OW'(16'd2048);
    endfunction

    // Lookup responder with a programmable latency in clocks.
    always @(negedge clk) begin
        if (!rst_n || !lk_req_valid) begin
            lk_rsp_ready = 1'b0;
            lat_cnt = 0;
        end else if (lat_cnt >= lat_set) begin
            lk_rsp_ready  = 1'b1;
            lk_rsp_offset = off_of(lk_req_addr);
        end else begin
            lk_rsp_ready = 1'b0;
            lat_cnt++;
        end
    end

    // Reset; returns at a falling edge with reset released.
    task automatic reset_dut(input bit mode);
        @(negedge clk);
        rst_n = 1'b0; rd_en = 1'b0; tag_valid = 1'b0;
        flow_code = '0; flush_code = '0; mode_window = mode;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exq.delete();
        m_mode = mode; m_cap = 0; m_hasprev = 0; m_ovf = 0; m_prev = '0;
    endtask

    // One clock: check the head if reading, drive, then update the model.
    task automatic step(input logic [2:0] f, input logic [1:0] fl, input bit tv,
                        input logic [AW-1:0] a, input bit rd);
        bit sync, act;
        int free;
        if (rd) begin
            if (exq.size() == 0) chk(0, "R12", 64'(rd_valid), 64'd0);
            else chk(rd_valid && (rd_data == exq[0]), "R12 R4 R5",
                     64'(rd_data), 64'(exq[0]));
        end
        if (lk_req_valid) chk(lk_req_addr == exp_lk, "R7", 64'(lk_req_addr), 64'(exp_lk));
        if (lk_req_valid && start_valid) chk(0, "R7", 64'(start_valid), 64'd0);
        flow_code = f; flush_code = fl; tag_valid = tv; tag_addr = a; rd_en = rd;
        @(posedge clk);
        sync = (f == 3'b011) && m_hasprev && (m_prev <= 3'd2);
        act  = m_cap || (m_mode ? sync : 1'b1);
        free = DEPTH - exq.size();
        if (rd && exq.size() > 0) void'(exq.pop_front());
        if (act) begin
            if (free >= 1) begin exq.push_back({1'b0, 27'd0, fl, f}); free--; end
            else m_ovf = 1;
            if (tv) begin
                if (free >= 1) exq.push_back({1'b1, a});
                else m_ovf = 1;
            end
        end
        m_cap = m_cap || act; m_prev = f; m_hasprev = 1;
        @(negedge clk);
        rd_en = 1'b0; tag_valid = 1'b0;
    endtask

    task automatic drain();
        int n = exq.size();
        for (int i = 0; i < n; i++) step(3'b000, 2'b10, 1'b0, '0, 1'b1);
    endtask

    task automatic run_window(input logic [2:0] v, input int lat);
        logic [AW-1:0] t1, t2, exp_s;
        logic [AW-1:0] held;
        reset_dut(1'b1);
        lat_set = lat;
        t1 = 32'h4000_0A00 + 32'(v) * 32;
        t2 = 32'h8000_0100 + 32'(v) * 8;
        exp_lk = t1 - 4;
        step(3'b000, 2'b00, 1'b0, '0, 1'b0);
        step(3'b011, 2'b01, 1'b0, '0, 1'b0);
        step(v,      2'b10, 1'b1, t1, 1'b0);
        step(3'b000, 2'b11, 1'b0, '0, 1'b0);
        step(3'b000, 2'b00, 1'b1, t2, 1'b0);
        for (int i = 0; i < 8; i++) step(3'(i), 2'(i), 1'b0, '0, 1'b0);
        case (v)
            3'b001: chk(start_valid && !start_err && start_addr == t1, "R6",
                        64'(start_addr), 64'(t1));
            3'b110: begin
                exp_s = t1 - 4 + {{(AW-OW){off_of(t1 - 4)[OW-1]}}, off_of(t1 - 4)};
                chk(start_valid && !start_err && start_addr == exp_s, "R7",
                    64'(start_addr), 64'(exp_s));
            end
            3'b101: chk(start_valid && !start_err && start_addr == t2, "R8",
                        64'(start_addr), 64'(t2));
            default: chk(start_err && !start_valid && capturing, "R9",
                         64'({start_err, start_valid, capturing}), 64'b101);
        endcase
        held = start_addr;
        drain();
        chk(start_addr == held && (start_valid || start_err), "R13",
            64'(start_addr), 64'(held));
        chk(overflow == 1'b0, "R11", 64'(overflow), 64'd0);
    endtask

    initial begin
        // Reset state.
        reset_dut(1'b1);
        chk(capturing == 0, "R2", 64'(capturing), 0);
        chk(rd_valid == 0, "R12", 64'(rd_valid), 0);
        chk(start_valid == 0 && start_err == 0, "R13", 64'({start_valid, start_err}), 0);
        chk(overflow == 0, "R11", 64'(overflow), 0);
        chk(lk_req_valid == 0, "R7", 64'(lk_req_valid), 0);

        // R1: marker context sweep over every previous code.
        for (int p = 0; p < 8; p++) begin
            reset_dut(1'b1);
            step(3'(p), 2'b00, 1'b0, '0, 1'b0);
            step(3'b011, 2'b10, 1'b1, 32'hA5A5_0000 + 32'(p), 1'b0);
            chk(capturing == (p <= 2), "R1", 64'(capturing), 64'(p <= 2));
            step(3'b001, 2'b00, 1'b0, '0, 1'b0);
            step(3'b000, 2'b01, 1'b0, '0, 1'b0);
            if (p > 2) chk(rd_valid == 0, "R2", 64'(rd_valid), 0);
            drain();
        end

        // R1: no marker on the first clock after reset, nor after 111.
        reset_dut(1'b1);
        step(3'b011, 2'b00, 1'b0, '0, 1'b0);
        chk(capturing == 0, "R1", 64'(capturing), 0);
        step(3'b111, 2'b00, 1'b0, '0, 1'b0);
        step(3'b011, 2'b00, 1'b0, '0, 1'b0);
        chk(capturing == 0 && rd_valid == 0, "R1", 64'(capturing), 0);
        step(3'b010, 2'b00, 1'b0, '0, 1'b0);
        step(3'b011, 2'b11, 1'b0, '0, 1'b0);
        chk(capturing == 1, "R2", 64'(capturing), 1);
        drain();

        // R6 R7 R8 R9: sweep of the code after the marker.
        for (int v = 0; v < 8; v++) run_window(3'(v), 1);
        // R7: direct-branch start under several lookup latencies.
        run_window(3'b110, 0);
        run_window(3'b110, 2);
        run_window(3'b110, 3);

        // R3 R10: back mode.
        reset_dut(1'b0);
        step(3'b010, 2'b01, 1'b0, '0, 1'b0);
        chk(capturing == 1 && rd_valid == 1, "R3", 64'({capturing, rd_valid}), 64'b11);
        step(3'b000, 2'b00, 1'b0, '0, 1'b0);
        step(3'b001, 2'b10, 1'b1, 32'h1234_5678, 1'b0);
        step(3'b101, 2'b11, 1'b1, 32'h0BAD_F00C, 1'b0);
        for (int i = 0; i < 3; i++) step(3'b110, 2'b00, 1'b0, '0, 1'b0);
        chk(start_valid && start_addr == 32'h1234_5678, "R10",
            64'(start_addr), 64'h1234_5678);
        drain();

        // R11 R5: FIFO full boundary with two pushes per clock.
        reset_dut(1'b0);
        step(3'b000, 2'b00, 1'b0, '0, 1'b0);
        for (int i = 0; i < 7; i++)
            step(3'(i), 2'(i), 1'b1, 32'hC000_0000 + 32'(i), 1'b0);
        chk(overflow == 0, "R11", 64'(overflow), 0);
        step(3'b101, 2'b01, 1'b1, 32'hC000_00FF, 1'b0);
        chk(overflow == 1 && exq.size() == DEPTH, "R11", 64'(overflow), 1);
        for (int i = 0; i < 3; i++) step(3'b001, 2'b10, 1'b1, 32'hD000_0000, 1'b0);
        drain();
        chk(overflow == 1 && m_ovf, "R11", 64'(overflow), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule